// File: doc/BRIEF.md
# Dual-Channel Interrupt Status and Mask Unit

This block collects two interrupt sources from each of two disk channels: the drive's device interrupt and the bus-master transfer-complete interrupt. A status bit captures each source on its rising edge. The bit stays set until software writes a 1 to it. Each channel has one mask bit, which blocks that channel's request from reaching the host without hiding its status.

Two byte locations on a small register bus expose the state. Offset 2 holds the channel 0 status. Offset 3 holds the channel 1 status, both mask bits and a read-only strap that reports a legacy header. When that strap is set, each channel drives its own fixed host line. When it is clear, both channels share one line, and the fixed lines sit idle.

Every host line is registered. Its active level follows a per-channel polarity input. The shared line uses the channel 0 polarity.

Top module: `irq_stat_mask_unit`

## Requirements
- R1: During and after synchronous reset (`rst` high) all four status bits and both mask bits are 0, and each host output rests at its inactive level.
- R2: A status bit sets on the cycle its source goes from 0 to 1. It stays set after the source falls. A source held high does not set it again once it has been cleared.
- R3: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a rising source and a clearing write land on the same clock edge, the bit ends up set.
- R4: A read of offset 2 returns channel 0 device status in bit 0 and channel 0 bus-master status in bit 1, with bits 7:2 reading 0.
- R5: A read of offset 3 returns the following bits: mask of channel 0 in bit 0, mask of channel 1 in bit 1, channel 1 device status in bit 2, channel 1 bus-master status in bit 3, and the legacy strap in bit 4. Bits 7:5 read 0. Offsets 0 and 1 read as 0.
- R6: Writing offset 3 loads bits 1:0 into the masks (1 = masked) and clears channel 1 status through bits 3:2. Bit 4 and writes to offsets 0 and 1 have no effect.
- R7: A masked channel keeps its status readable but does not assert any host line. Unmasking a channel with pending status asserts its line.
- R8: With the legacy strap high, channel 0's request drives `irq_fixed_a`, channel 1's request drives `irq_fixed_b`, and `irq_shared` stays inactive.
- R9: With the legacy strap low, `irq_shared` is asserted when either unmasked channel has any status set, and both fixed lines stay inactive.
- R10: A channel's line is active-high when its polarity input is 0 and active-low when it is 1. `irq_shared` follows channel 0 polarity. Each output reflects the status, mask, strap and polarity one clock edge after they change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_irq | input | 2 | Device interrupt source, one bit per channel |
| bm_irq | input | 2 | Bus-master interrupt source, one bit per channel |
| legacy_strap | input | 1 | 1 = fixed per-channel lines, 0 = shared line |
| pol_low | input | 2 | Per-channel polarity, 1 = active-low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write byte offset |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read byte offset |
| rd_data | output | 8 | Register read data (combinational) |
| irq_fixed_a | output | 1 | Fixed host line for channel 0 |
| irq_fixed_b | output | 1 | Fixed host line for channel 1 |
| irq_shared | output | 1 | Shared host line |

## Verification
A status bit stuck, lost or cleared by the wrong write shows up on the next read of its offset, and on the host line one edge later. A wrong mask or routing choice shows up within two edges of the stimulus, as a host line that is asserted when it should rest or stays at rest when it should be asserted. The bench sweeps every combination of source pattern, mask, polarity and strap, and compares both register offsets and all three lines against values derived from the requirements. This exposes any mis-placed bit or crossed channel.

// File: rtl/irqsm_pkg.sv
package irqsm_pkg;
    localparam int NUM_CH   = 2;
    localparam int SRC_PER  = 2;
    localparam int NUM_SRC  = NUM_CH * SRC_PER;
    localparam int ADDR_W   = 2;
    localparam int DATA_W   = 8;

    localparam logic [ADDR_W-1:0] OFF_STAT_CH0 = 2'd2;
    localparam logic [ADDR_W-1:0] OFF_STAT_CH1 = 2'd3;

    // bit positions that software decodes
    localparam int B_DEV      = 0;
    localparam int B_BM       = 1;
    localparam int B_MASK0    = 0;
    localparam int B_MASK1    = 1;
    localparam int B_DEV1     = 2;
    localparam int B_BM1      = 3;
    localparam int B_LEGACY   = 4;

    typedef struct packed {
        logic bm;
        logic dev;
    } chan_stat_t;

    typedef enum logic {
        ROUTE_SHARED = 1'b0,
        ROUTE_FIXED  = 1'b1
    } route_mode_t;

    // level driven on a host line for a logical request
    function automatic logic drive_level(input logic req, input logic low);
        return req ^ low;
    endfunction

    function automatic logic chan_request(input chan_stat_t s, input logic masked);
        return (s.dev | s.bm) & ~masked;
    endfunction
endpackage

// File: rtl/irqsm_src_latch.sv
module irqsm_src_latch #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] src,
    input  logic [W-1:0] clr,
    output logic [W-1:0] stat
);
    logic [W-1:0] src_q;
    logic [W-1:0] rise;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign rise[i] = src[i] & ~src_q[i];

        always_ff @(posedge clk) begin
            if (rst) begin
                src_q[i] <= 1'b0;
                stat[i]  <= 1'b0;
            end else begin
                src_q[i] <= src[i];
                stat[i]  <= (stat[i] & ~clr[i]) | rise[i];
            end
        end

        p_set_on_rise_r2: assert property (@(posedge clk) disable iff (rst)
            (src[i] && !src_q[i]) |=> stat[i]);
        p_clear_r3: assert property (@(posedge clk) disable iff (rst)
            (clr[i] && !(src[i] && !src_q[i])) |=> !stat[i]);
        p_hold_r3: assert property (@(posedge clk) disable iff (rst)
            (!clr[i] && !(src[i] && !src_q[i])) |=> $stable(stat[i]));
    end
endmodule

// File: rtl/irqsm_regs.sv
module irqsm_regs
    import irqsm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  chan_stat_t        stat0,
    input  chan_stat_t        stat1,
    input  logic              legacy,
    output logic [DATA_W-1:0] rd_data,
    output logic [SRC_PER-1:0] clr0,
    output logic [SRC_PER-1:0] clr1,
    output logic [NUM_CH-1:0]  mask
);
    logic hit0;
    logic hit1;

    assign hit0 = wr_en && (wr_addr == OFF_STAT_CH0);
    assign hit1 = wr_en && (wr_addr == OFF_STAT_CH1);

    always_comb begin
        clr0 = '0;
        clr1 = '0;
        if (hit0) begin
            clr0[0] = wr_data[B_DEV];
            clr0[1] = wr_data[B_BM];
        end
        if (hit1) begin
            clr1[0] = wr_data[B_DEV1];
            clr1[1] = wr_data[B_BM1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
        end else if (hit1) begin
            mask[0] <= wr_data[B_MASK0];
            mask[1] <= wr_data[B_MASK1];
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            OFF_STAT_CH0: begin
                rd_data[B_DEV] = stat0.dev;
                rd_data[B_BM]  = stat0.bm;
            end
            OFF_STAT_CH1: begin
                rd_data[B_MASK0]  = mask[0];
                rd_data[B_MASK1]  = mask[1];
                rd_data[B_DEV1]   = stat1.dev;
                rd_data[B_BM1]    = stat1.bm;
                rd_data[B_LEGACY] = legacy;
            end
            default: rd_data = '0;
        endcase
    end

    p_mask_load_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == OFF_STAT_CH1) |=> (mask == $past(wr_data[1:0])));
    p_mask_keep_r6: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_addr == OFF_STAT_CH1) |=> $stable(mask));
endmodule

// File: rtl/irqsm_route.sv
module irqsm_route
    import irqsm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  chan_stat_t        stat0,
    input  chan_stat_t        stat1,
    input  logic [NUM_CH-1:0] mask,
    input  logic              legacy,
    input  logic [NUM_CH-1:0] pol_low,
    output logic              line_a,
    output logic              line_b,
    output logic              line_sh
);
    route_mode_t mode;
    logic [NUM_CH-1:0] req;
    logic nxt_a;
    logic nxt_b;
    logic nxt_sh;

    assign mode   = legacy ? ROUTE_FIXED : ROUTE_SHARED;
    assign req[0] = chan_request(stat0, mask[0]);
    assign req[1] = chan_request(stat1, mask[1]);

    always_comb begin
        nxt_a  = drive_level(1'b0, pol_low[0]);
        nxt_b  = drive_level(1'b0, pol_low[1]);
        nxt_sh = drive_level(1'b0, pol_low[0]);
        case (mode)
            ROUTE_FIXED: begin
                nxt_a = drive_level(req[0], pol_low[0]);
                nxt_b = drive_level(req[1], pol_low[1]);
            end
            default: nxt_sh = drive_level(|req, pol_low[0]);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_a  <= pol_low[0];
            line_b  <= pol_low[1];
            line_sh <= pol_low[0];
        end else begin
            line_a  <= nxt_a;
            line_b  <= nxt_b;
            line_sh <= nxt_sh;
        end
    end

    p_shared_idle_r8: assert property (@(posedge clk) disable iff (rst)
        legacy |=> (line_sh == $past(pol_low[0])));
    p_fixed_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !legacy |=> (line_a == $past(pol_low[0]) && line_b == $past(pol_low[1])));
    p_masked_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (legacy && mask[0]) |=> (line_a == $past(pol_low[0])));
endmodule

// File: rtl/irq_stat_mask_unit.sv
module irq_stat_mask_unit
    import irqsm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        dev_irq,
    input  logic [1:0]        bm_irq,
    input  logic              legacy_strap,
    input  logic [1:0]        pol_low,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [1:0]        rd_addr,
    output logic [7:0]        rd_data,
    output logic              irq_fixed_a,
    output logic              irq_fixed_b,
    output logic              irq_shared
);
    logic [NUM_SRC-1:0] src_vec;
    logic [NUM_SRC-1:0] clr_vec;
    logic [NUM_SRC-1:0] stat_vec;
    logic [SRC_PER-1:0] clr0;
    logic [SRC_PER-1:0] clr1;
    logic [NUM_CH-1:0]  mask;
    chan_stat_t         stat0;
    chan_stat_t         stat1;

    // order: {ch1.bm, ch1.dev, ch0.bm, ch0.dev}
    assign src_vec = {bm_irq[1], dev_irq[1], bm_irq[0], dev_irq[0]};
    assign clr_vec = {clr1, clr0};
    assign stat0   = '{bm: stat_vec[1], dev: stat_vec[0]};
    assign stat1   = '{bm: stat_vec[3], dev: stat_vec[2]};

    irqsm_src_latch #(.W(NUM_SRC)) u_latch (
        .clk  (clk),
        .rst  (rst),
        .src  (src_vec),
        .clr  (clr_vec),
        .stat (stat_vec)
    );

    irqsm_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .stat0   (stat0),
        .stat1   (stat1),
        .legacy  (legacy_strap),
        .rd_data (rd_data),
        .clr0    (clr0),
        .clr1    (clr1),
        .mask    (mask)
    );

    irqsm_route u_route (
        .clk     (clk),
        .rst     (rst),
        .stat0   (stat0),
        .stat1   (stat1),
        .mask    (mask),
        .legacy  (legacy_strap),
        .pol_low (pol_low),
        .line_a  (irq_fixed_a),
        .line_b  (irq_fixed_b),
        .line_sh (irq_shared)
    );

    p_reset_clean_r1: assert property (@(posedge clk)
        rst |=> (stat_vec == '0 && mask == '0));
endmodule

// File: tb/irq_stat_mask_unit_bench.sv
module irq_stat_mask_unit_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] dev_irq = '0;
    logic [1:0] bm_irq = '0;
    logic       legacy_strap = 1'b0;
    logic [1:0] pol_low = '0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       irq_fixed_a;
    logic       irq_fixed_b;
    logic       irq_shared;

    int n_run = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_stat_mask_unit u_irq_stat_mask_unit (
        .clk(clk), .rst(rst), .dev_irq(dev_irq), .bm_irq(bm_irq),
        .legacy_strap(legacy_strap), .pol_low(pol_low),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_fixed_a(irq_fixed_a), .irq_fixed_b(irq_fixed_b),
        .irq_shared(irq_shared)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
        rd_addr = a;
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            finish_run();
        end
    end

    initial begin
        logic r0, r1, exp_a, exp_b, exp_s;
        repeat (3) @(negedge clk);
        // R1: reset state
        rd_chk("R1 off2", 2'd2, 8'h00);
        rd_chk("R1 off3", 2'd3, 8'h00);
        chk("R1 line a", {7'b0, irq_fixed_a}, 8'h00);
        chk("R1 shared", {7'b0, irq_shared}, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        rd_chk("R1 after release", 2'd2, 8'h00);

        // R5: offsets 0 and 1 read zero
        rd_chk("R5 off0", 2'd0, 8'h00);
        rd_chk("R5 off1", 2'd1, 8'h00);

        // R2: held-high source does not re-set after clear
        dev_irq[0] = 1'b1;
        @(negedge clk);
        rd_chk("R2 set", 2'd2, 8'h01);
        wr(2'd2, 8'h01);
        @(negedge clk);
        rd_chk("R2 no reset on level", 2'd2, 8'h00);
        dev_irq[0] = 1'b0;
        @(negedge clk);

        // R3: set wins over same-edge clear; write 0 keeps bit
        @(negedge clk);
        dev_irq[0] = 1'b1; wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h01;
        @(negedge clk);
        wr_en = 1'b0; dev_irq[0] = 1'b0;
        rd_chk("R3 set wins", 2'd2, 8'h01);
        wr(2'd2, 8'h00);
        rd_chk("R3 write zero", 2'd2, 8'h01);
        wr(2'd2, 8'h03);
        rd_chk("R3 clear", 2'd2, 8'h00);

        // R6: read-only strap bit and dead offsets
        wr(2'd3, 8'h10);
        rd_chk("R6 strap ro", 2'd3, 8'h00);
        wr(2'd0, 8'hFF);
        wr(2'd1, 8'hFF);
        rd_chk("R6 off0 write", 2'd3, 8'h00);
        rd_chk("R6 off1 write", 2'd0, 8'h00);

        // R7: unmasking pending status asserts line
        legacy_strap = 1'b1; pol_low = 2'b00;
        wr(2'd3, 8'h02);
        @(negedge clk);
        bm_irq[1] = 1'b1;
        @(negedge clk);
        bm_irq[1] = 1'b0;
        @(negedge clk);
        rd_chk("R7 visible masked", 2'd3, 8'h1A);
        chk("R7 masked quiet", {7'b0, irq_fixed_b}, 8'h00);
        wr(2'd3, 8'h00);
        @(negedge clk);
        chk("R7 unmask asserts", {7'b0, irq_fixed_b}, 8'h01);

        // Sweep: strap x polarity x mask x source pattern (R2..R10)
        for (int lg = 0; lg < 2; lg++) begin
            for (int pl = 0; pl < 4; pl++) begin
                for (int m = 0; m < 4; m++) begin
                    for (int p = 0; p < 16; p++) begin
                        legacy_strap = lg[0];
                        pol_low = pl[1:0];
                        wr(2'd3, 8'h0C | 8'(m));
                        wr(2'd2, 8'h03);
                        dev_irq = {p[2], p[0]};
                        bm_irq  = {p[3], p[1]};
                        @(negedge clk);
                        dev_irq = '0; bm_irq = '0;
                        @(negedge clk);
                        rd_chk("R4 sweep off2", 2'd2, {6'b0, p[1], p[0]});
                        rd_chk("R5 sweep off3", 2'd3,
                               {3'b0, lg[0], p[3], p[2], m[1], m[0]});
                        r0 = (p[0] | p[1]) & ~m[0];
                        r1 = (p[2] | p[3]) & ~m[1];
                        if (lg[0]) begin
                            exp_a = r0 ^ pl[0];
                            exp_b = r1 ^ pl[1];
                            exp_s = pl[0];
                        end else begin
                            exp_a = pl[0];
                            exp_b = pl[1];
                            exp_s = (r0 | r1) ^ pl[0];
                        end
                        chk(lg[0] ? "R8 R10 line a" : "R9 R10 line a",
                            {7'b0, irq_fixed_a}, {7'b0, exp_a});
                        chk(lg[0] ? "R8 R10 line b" : "R9 R10 line b",
                            {7'b0, irq_fixed_b}, {7'b0, exp_b});
                        chk(lg[0] ? "R8 R10 shared" : "R9 R7 shared",
                            {7'b0, irq_shared}, {7'b0, exp_s});
                    end
                end
            end
        end
        done = 1'b1;
        finish_run();
    end
endmodule